// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block collects interrupt requests for a small processor core. Ten sources feed sticky flag bits. Three of them are core sources: an external pin edge, a timer-0 overflow and a change on four port pins. Their flags and enables live in the control register. The other seven are peripheral sources: comparator, serial transmit, serial receive, capture/compare, timer-1 overflow, timer-2 match and data EEPROM write done. They keep their flags and enables in two registers of their own, and they also pass through a shared peripheral-group enable. A global enable sits above every source. A flag is set by its event no matter which enables are set, and only a register write clears it.

The CPU sees a registered request `irq_o`, which carries the fixed vector 0x0004 on `vec_o`. The CPU answers with three strobes. Accepting an interrupt drops the global enable. Returning from the handler raises it again. The third strobe reports an instruction that cleared the global enable, and it blocks a request that would otherwise be raised in the next cycle. A separate wake-up output follows every enabled, pending flag and ignores the global enable, so a sleeping core can be woken even with interrupts masked.

The external pin and the four port pins pass through two synchronizer flops. The external source fires on a rising or falling edge, chosen by configuration. The port-change flag stays set for as long as the synchronized pins differ from a snapshot, and that snapshot is taken on each read of the port register.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, addresses 0, 1 and 2 read 0x00 and address 3 reads 0x10 with the pins low. `irq_o`, `wake_o` and `vec_o` are 0.
- R2: Each event sets its flag regardless of its own enable, the group enable or the global enable. The control register (addr 0) holds: bit 0 port-change flag, bit 1 external flag, bit 2 timer-0 flag, bit 3 port-change enable, bit 4 external enable, bit 5 timer-0 enable, bit 6 group enable, bit 7 global enable. Peripheral flags (addr 1) and enables (addr 2) use bit i for `periph_evt_i[i]`.
- R3: Writing 0 to a flag bit clears it. If an event happens in the same cycle as that write, the flag stays set.
- R4: A core source raises `irq_o` only when its flag, its enable and the global enable are all 1. `irq_o` rises one cycle after the flag becomes visible, and the group enable has no effect on core sources.
- R5: A peripheral source raises `irq_o` only when its flag, its enable, the group enable and the global enable are all 1, with the same one-cycle latency as R4.
- R6: `wake_o` is 1 in the same cycle that an enabled flag (a peripheral flag also needing the group enable) is visible. The global enable has no effect on it.
- R7: `vec_o` is 0x0004 while `irq_o` is 1 and 0 otherwise. A `take_i` strobe clears the global enable, and `irq_o` is 0 in the next cycle.
- R8: A `reti_i` strobe sets the global enable. A request that is still pending raises `irq_o` one cycle later.
- R9: After a `gie_clr_i` strobe, `irq_o` is 0 in the next cycle even if a request was due, and the global enable is cleared. The request stays pending and returns one cycle after the global enable is set again.
- R10: With address 3 bit 4 set to 1 (the reset value), the external flag sets on a rising edge of the pin. With that bit set to 0, it sets on a falling edge, and edges of the other direction are ignored. The flag becomes visible after the third clock edge following the pin change.
- R11: The port-change flag sets after the third edge following a pin change, and it keeps re-setting while the pins differ from the snapshot. A read strobe on address 3 returns the synchronized pins in bits 3:0 and loads the snapshot from them.
- R12: Hardware never clears a flag. Taking an interrupt leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (latches port snapshot at addr 3) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| port_pin_i | input | 4 | Asynchronous change-monitored port pins |
| tmr0_ovf_i | input | 1 | Timer-0 overflow pulse |
| periph_evt_i | input | 7 | Peripheral event pulses |
| take_i | input | 1 | CPU accepts the interrupt |
| reti_i | input | 1 | CPU returns from the interrupt |
| gie_clr_i | input | 1 | Instruction cleared the global enable |
| irq_o | output | 1 | Registered interrupt request to the CPU |
| vec_o | output | 16 | Vector address, valid with irq_o |
| wake_o | output | 1 | Wake-up request, independent of global enable |

## Verification
A wrong flag shows up at the register port in the cycle after its event, and at `wake_o` in that same cycle. A wrong enable or gating term shows up at `irq_o` exactly one edge later. A global enable in the wrong state after a CPU strobe shows up as a request that is wrong in the very next cycle. The bench sweeps every source against every combination of its own enable, the group enable and the global enable. It checks each result at the exact cycle it is due, so a gating or latency error cannot go unseen.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 2;
  localparam int unsigned N_CORE  = 3;
  localparam int unsigned N_PERI  = 7;
  localparam int unsigned N_PORT  = 4;
  localparam int unsigned SYNC_N  = 2;
  localparam int unsigned VW      = 16;
  localparam logic [VW-1:0] VECTOR = 16'h0004;
  // register addresses
  localparam logic [AW-1:0] A_CTL  = 2'd0;
  localparam logic [AW-1:0] A_PFLG = 2'd1;
  localparam logic [AW-1:0] A_PEN  = 2'd2;
  localparam logic [AW-1:0] A_PORT = 2'd3;
  // control register layout
  localparam int unsigned B_CEN  = N_CORE;      // core enables start here
  localparam int unsigned B_GRP  = 6;
  localparam int unsigned B_GIE  = 7;
  localparam int unsigned B_EDGE = N_PORT;      // edge select in addr 3
  // core source index
  localparam int unsigned C_PC   = 0;
  localparam int unsigned C_EXT  = 1;
  localparam int unsigned C_T0   = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    if (STAGES > 1) begin : g_chain
      assign stg_d = {stg_q[STAGES-2:0], d_i};
    end else begin : g_single
      assign stg_d = d_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_val_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;

  // an event always wins over a clearing write
  always_comb begin
    flag_d = wr_en_i ? wr_val_i : flag_q;
    flag_d = flag_d | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              ext_pin_i,
  input  logic [N_PORT-1:0] port_pin_i,
  input  logic              tmr0_ovf_i,
  input  logic [N_PERI-1:0] periph_evt_i,
  input  logic              take_i,
  input  logic              reti_i,
  input  logic              gie_clr_i,
  output logic              irq_o,
  output logic [VW-1:0]     vec_o,
  output logic              wake_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  // pin synchronizers
  logic              ext_s;
  logic [N_PORT-1:0] port_s;
  irq_sync #(.W(1), .STAGES(SYNC_N)) u_ext_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(ext_pin_i), .q_o(ext_s));
  irq_sync #(.W(N_PORT), .STAGES(SYNC_N)) u_port_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(port_pin_i), .q_o(port_s));

  // state
  logic              gie_q, gie_d;
  logic              grp_q, grp_d;
  logic [N_CORE-1:0] cen_q, cen_d;
  logic [N_PERI-1:0] pen_q, pen_d;
  logic              rise_q, rise_d;
  logic [N_PORT-1:0] snap_q, snap_d;
  logic              ext_prev_q;
  logic              irq_q, irq_d;

  logic wr_ctl, wr_pflg, wr_pen, wr_port, rd_port;
  assign wr_ctl  = wr_i && (addr_i == A_CTL);
  assign wr_pflg = wr_i && (addr_i == A_PFLG);
  assign wr_pen  = wr_i && (addr_i == A_PEN);
  assign wr_port = wr_i && (addr_i == A_PORT);
  assign rd_port = rd_i && (addr_i == A_PORT);

  // event detection
  logic              ext_evt, pc_evt;
  logic [N_CORE-1:0] core_evt;
  assign ext_evt = rise_q ? (ext_s & ~ext_prev_q) : (~ext_s & ext_prev_q);
  assign pc_evt  = |(port_s ^ snap_q);
  always_comb begin
    core_evt        = '0;
    core_evt[C_PC]  = pc_evt;
    core_evt[C_EXT] = ext_evt;
    core_evt[C_T0]  = tmr0_ovf_i;
  end

  // flags
  logic [N_CORE-1:0] cflag;
  logic [N_PERI-1:0] pflag;
  irq_flag_reg #(.N(N_CORE)) u_core_flags (
    .clk(clk), .rst_n(rst_sync_n), .wr_en_i(wr_ctl),
    .wr_val_i(wdata_i[N_CORE-1:0]), .evt_i(core_evt), .flag_o(cflag));
  irq_flag_reg #(.N(N_PERI)) u_peri_flags (
    .clk(clk), .rst_n(rst_sync_n), .wr_en_i(wr_pflg),
    .wr_val_i(wdata_i[N_PERI-1:0]), .evt_i(periph_evt_i), .flag_o(pflag));

  // gating
  logic pend;
  assign pend   = (|(cflag & cen_q)) | (grp_q & (|(pflag & pen_q)));
  assign wake_o = pend;

  // next state
  always_comb begin
    gie_d  = gie_q;
    grp_d  = grp_q;
    cen_d  = cen_q;
    pen_d  = pen_q;
    rise_d = rise_q;
    snap_d = snap_q;
    if (wr_ctl) begin
      gie_d = wdata_i[B_GIE];
      grp_d = wdata_i[B_GRP];
      cen_d = wdata_i[B_CEN +: N_CORE];
    end
    if (wr_pen)  pen_d  = wdata_i[N_PERI-1:0];
    if (wr_port) rise_d = wdata_i[B_EDGE];
    if (rd_port) snap_d = port_s;
    if (reti_i)  gie_d  = 1'b1;
    if (take_i || gie_clr_i) gie_d = 1'b0;
    irq_d = gie_q & pend & ~take_i & ~gie_clr_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gie_q      <= 1'b0;
      grp_q      <= 1'b0;
      cen_q      <= '0;
      pen_q      <= '0;
      rise_q     <= 1'b1;
      snap_q     <= '0;
      ext_prev_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      gie_q      <= gie_d;
      grp_q      <= grp_d;
      cen_q      <= cen_d;
      if (wr_pen)  pen_q  <= pen_d;
      if (wr_port) rise_q <= rise_d;
      if (rd_port) snap_q <= snap_d;
      ext_prev_q <= ext_s;
      irq_q      <= irq_d;
    end
  end

  assign irq_o = irq_q;
  assign vec_o = irq_q ? VECTOR : '0;

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTL:  rdata_o = {gie_q, grp_q, cen_q, cflag};
      A_PFLG: rdata_o[N_PERI-1:0] = pflag;
      A_PEN:  rdata_o[N_PERI-1:0] = pen_q;
      default: begin
        rdata_o[N_PORT-1:0] = port_s;
        rdata_o[B_EDGE]     = rise_q;
      end
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       take_i,
  input logic       reti_i,
  input logic       gie_clr_i,
  input logic       wr_i,
  input logic       tmr0_ovf_i,
  input logic       irq_o,
  input logic       gie,
  input logic [9:0] flags
);
  a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (!gie && !irq_o));
  a_r9_clr_masks: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |=> (!gie && !irq_o));
  a_r8_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_i && !gie_clr_i) |=> gie);
  a_r4_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(gie));
  a_r12_take_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !wr_i) |=> ((flags & $past(flags)) == $past(flags)));
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf_i |=> flags[2]);
endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .take_i(take_i), .reti_i(reti_i),
  .gie_clr_i(gie_clr_i), .wr_i(wr_i), .tmr0_ovf_i(tmr0_ovf_i),
  .irq_o(irq_o), .gie(gie_q), .flags({pflag, cflag}));

// File: tb/test_irq_ctrl_top.sv
module test_irq_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        ext_pin_i = 1'b0;
  logic [3:0]  port_pin_i = '0;
  logic        tmr0_ovf_i = 1'b0;
  logic [6:0]  periph_evt_i = '0;
  logic        take_i = 1'b0, reti_i = 1'b0, gie_clr_i = 1'b0;
  logic        irq_o, wake_o;
  logic [15:0] vec_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_ctrl_top i_irq_ctrl_top (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr_i = a; #1; v = rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    waitn(3); rst_n = 1'b1; waitn(4);
    // R1 reset state
    peek(2'd0, v); check("R1 ctl", 16'(v), 16'h00);
    peek(2'd1, v); check("R1 pflg", 16'(v), 16'h00);
    peek(2'd2, v); check("R1 pen", 16'(v), 16'h00);
    peek(2'd3, v); check("R1 port", 16'(v), 16'h10);
    check("R1 irq", 16'(irq_o), 16'h0);
    check("R1 wake", 16'(wake_o), 16'h0);
    check("R1 vec", vec_o, 16'h0);

    // peripheral sweep: R2 R5 R6 R7
    for (int s = 0; s < 7; s++) begin
      for (int c = 0; c < 8; c++) begin
        logic en, grp, gie;
        en = c[0]; grp = c[1]; gie = c[2];
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        wr(2'd2, 8'(en) << s);
        wr(2'd0, {gie, grp, 6'b0});
        periph_evt_i = 7'(1 << s);
        @(negedge clk); periph_evt_i = '0;
        peek(2'd1, v); check("R2 peri flag", 16'(v), 16'(1 << s));
        check("R6 peri wake", 16'(wake_o), 16'(en & grp));
        @(negedge clk);
        check("R5 peri irq", 16'(irq_o), 16'(en & grp & gie));
        check("R7 vec", vec_o, (en & grp & gie) ? 16'h0004 : 16'h0000);
      end
    end

    // core timer-0 sweep: R4 R6 (group enable irrelevant)
    for (int c = 0; c < 8; c++) begin
      logic en, grp, gie;
      en = c[0]; grp = c[1]; gie = c[2];
      wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
      wr(2'd0, {gie, grp, en, 5'b0});
      tmr0_ovf_i = 1'b1;
      @(negedge clk); tmr0_ovf_i = 1'b0;
      peek(2'd0, v); check("R2 core flag", 16'(v[2]), 16'h1);
      check("R6 core wake", 16'(wake_o), 16'(en));
      @(negedge clk);
      check("R4 core irq", 16'(irq_o), 16'(en & gie));
    end

    // R3 clear by write, event wins over clear
    wr(2'd0, 8'h00); waitn(1);
    peek(2'd0, v); check("R3 cleared", 16'(v), 16'h00);
    @(negedge clk); addr_i = 2'd0; wdata_i = 8'h00; wr_i = 1'b1; tmr0_ovf_i = 1'b1;
    @(negedge clk); wr_i = 1'b0; tmr0_ovf_i = 1'b0;
    peek(2'd0, v); check("R3 event wins", 16'(v[2]), 16'h1);
    wr(2'd0, 8'h00);
    peek(2'd0, v); check("R3 write clears", 16'(v[2]), 16'h0);

    // R11 port change
    port_pin_i = 4'b0101;
    waitn(2); peek(2'd0, v); check("R11 not yet", 16'(v[0]), 16'h0);
    waitn(1); peek(2'd0, v); check("R11 set", 16'(v[0]), 16'h1);
    wr(2'd0, 8'h00);
    peek(2'd0, v); check("R11 level persists", 16'(v[0]), 16'h1);
    @(negedge clk); addr_i = 2'd3; rd_i = 1'b1; #1;
    check("R11 port read", 16'(rdata_o), 16'h15);
    @(negedge clk); rd_i = 1'b0;
    wr(2'd0, 8'h00); waitn(2);
    peek(2'd0, v); check("R11 snapshot clears", 16'(v[0]), 16'h0);
    port_pin_i = 4'b0100;
    waitn(3); peek(2'd0, v); check("R11 new change", 16'(v[0]), 16'h1);
    @(negedge clk); addr_i = 2'd3; rd_i = 1'b1;
    @(negedge clk); rd_i = 1'b0;
    wr(2'd0, 8'h00);

    // R10 external edge select
    @(negedge clk); ext_pin_i = 1'b1;
    waitn(2); peek(2'd0, v); check("R10 rise latency", 16'(v[1]), 16'h0);
    waitn(1); peek(2'd0, v); check("R10 rise set", 16'(v[1]), 16'h1);
    wr(2'd0, 8'h00);
    ext_pin_i = 1'b0; waitn(4);
    peek(2'd0, v); check("R10 fall ignored", 16'(v[1]), 16'h0);
    wr(2'd3, 8'h00);
    ext_pin_i = 1'b1; waitn(4);
    peek(2'd0, v); check("R10 rise ignored", 16'(v[1]), 16'h0);
    ext_pin_i = 1'b0;
    waitn(2); peek(2'd0, v); check("R10 fall latency", 16'(v[1]), 16'h0);
    waitn(1); peek(2'd0, v); check("R10 fall set", 16'(v[1]), 16'h1);
    wr(2'd0, 8'h00);

    // R7 R8 R9 R12 CPU handshake
    wr(2'd0, 8'hA0);
    tmr0_ovf_i = 1'b1;
    @(negedge clk); tmr0_ovf_i = 1'b0;
    @(negedge clk); check("R7 irq up", 16'(irq_o), 16'h1);
    check("R7 vector", vec_o, 16'h0004);
    take_i = 1'b1;
    @(negedge clk); take_i = 1'b0;
    check("R7 take drops irq", 16'(irq_o), 16'h0);
    peek(2'd0, v); check("R7 gie cleared", 16'(v[7]), 16'h0);
    check("R12 flag kept", 16'(v[2]), 16'h1);
    waitn(2); check("R7 stays low", 16'(irq_o), 16'h0);
    reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0;
    check("R8 not yet", 16'(irq_o), 16'h0);
    peek(2'd0, v); check("R8 gie set", 16'(v[7]), 16'h1);
    @(negedge clk); check("R8 pending serviced", 16'(irq_o), 16'h1);
    gie_clr_i = 1'b1;
    @(negedge clk); gie_clr_i = 1'b0;
    check("R9 suppressed", 16'(irq_o), 16'h0);
    peek(2'd0, v); check("R9 gie cleared", 16'(v[7]), 16'h0);
    waitn(3); check("R9 stays low", 16'(irq_o), 16'h0);
    peek(2'd0, v); check("R9 still pending", 16'(v[2]), 16'h1);
    wr(2'd0, 8'hA4);
    check("R9 one cycle", 16'(irq_o), 16'h0);
    @(negedge clk); check("R9 returns", 16'(irq_o), 16'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule